// File: doc/BRIEF.md
# SONET Serial Frame Aligner

This block sits behind a line receiver that already delivers a recovered bit clock and NRZ data. It turns the serial stream into byte-wide words and marks each new word with a one-bit-clock strobe. The strobe fires once every eight bit clocks, which gives the byte-rate timing reference. Every bit clock it compares the most recent 48 received bits with the framing sequence: three A1 bytes (0xF6) followed by three A2 bytes (0x28), sent most significant bit first. The sequence is found whatever its bit offset is relative to the current byte phase.

The hunt is controlled by a level-sensitive out-of-frame request. While the request is high, each detected sequence moves the byte boundary so that the third A2 byte becomes a parallel word. A frame pulse is raised with that word, and the block keeps hunting after it has locked. A detection is also accepted in the bit clock just after the request falls. Otherwise the boundary in use is kept, and a detection produces no pulse. For a frame to be captured, the request should be raised at least four byte times before the A1/A2 boundary of that frame. A loss-of-signal input forces every word captured while it is high to zero.

Top module: `sonet_frame_aligner`

## Requirements
- R1: Serial data is sampled on the rising clock edge, and bits are packed most significant bit first: the earliest-received bit of a word appears on byte_out[7].
- R2: With no realignment, byte_stb is high for exactly one bit clock in every eight, and byte_out changes only in the cycle where byte_stb is high.
- R3: The 48-bit sequence F6 F6 F6 28 28 28 is detected at any bit offset 0 to 7 relative to the current byte phase.
- R4: When an accepted detection occurs, in the bit clock after the last A2 bit was sampled, byte_stb is high, byte_out is 0x28 and frame_pulse is high. The following words are aligned to the new boundary.
- R5: frame_pulse rises together with the strobe of the third A2 word and stays high for exactly 8 bit clocks, one byte period.
- R6: While oof_req is high, each new detection realigns the boundary and raises frame_pulse, including when the block is already locked.
- R7: A detection is accepted only if oof_req was high at the clock edge that sampled the last pattern bit, or at the edge after it. Otherwise no frame pulse is raised and the previous byte boundary is kept.
- R8: Any word captured while los_in is high is output as 0x00, and frame_pulse is unaffected.
- R9: During and just after synchronous reset, byte_out is 0, byte_stb is 0 and frame_pulse is 0. The byte phase starts at offset 0, so the first strobe appears after the 8th clock edge following reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial NRZ data |
| oof_req | input | 1 | Out-of-frame request, level-sensitive |
| los_in | input | 1 | Loss of signal, forces captured words to zero |
| byte_out | output | 8 | Parallel data word |
| byte_stb | output | 1 | High for one bit clock when byte_out updates |
| frame_pulse | output | 1 | High for one byte period starting with the third A2 word |

## Verification
The hardest case to reach is the one-cycle acceptance window around the falling edge of the request. Whether a frame locks depends on the request dropping exactly one bit clock before or after the last A2 bit is sampled. The driver therefore counts bits to the edge and releases the request with the 48th pattern bit in one run, and with the first bit after the pattern in another. To show that the old boundary is kept, the rejected sequences are placed at a bit offset that breaks the byte phase. Padding then restores the old phase, so known payload words only read back correctly if no realignment took place.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
  localparam int unsigned SFA_BYTE_W = 8;
  localparam int unsigned SFA_N_A1   = 3;
  localparam int unsigned SFA_N_A2   = 3;
  localparam logic [7:0]  SFA_A1     = 8'hF6;
  localparam logic [7:0]  SFA_A2     = 8'h28;
endpackage

// File: rtl/sfa_hunt.sv
module sfa_hunt #(
  parameter int unsigned W  = 8,
  parameter int unsigned N1 = 3,
  parameter int unsigned N2 = 3,
  parameter logic [W-1:0] A1 = 8'hF6,
  parameter logic [W-1:0] A2 = 8'h28
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         din,
  output logic [W-1:0] last_word,
  output logic         hit
);
  localparam int unsigned NB   = N1 + N2;
  localparam int unsigned SR_W = W * NB;

  logic [SR_W-1:0] sr;
  logic [SR_W-1:0] pat;

  // Pattern is built from the byte values, first byte in the top slice.
  for (genvar i = 0; i < NB; i++) begin : g_pat
    if (i < N1) begin : g_a1
      assign pat[SR_W-1-i*W -: W] = A1;
    end else begin : g_a2
      assign pat[SR_W-1-i*W -: W] = A2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[SR_W-2:0], din};
  end

  assign hit       = (sr == pat);
  assign last_word = sr[W-1:0];

  // R3: a hit means the bit just sampled was the final pattern bit
  assert_hit_tail_R3: assert property (@(posedge clk) disable iff (rst)
    hit |-> ($past(din) == A2[0]));
endmodule

// File: rtl/sfa_bytectl.sv
module sfa_bytectl #(
  parameter int unsigned W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic oof,
  output logic cap,
  output logic stb,
  output logic fp
);
  localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [CNT_W-1:0] cnt;
  logic             oof_q;
  logic             gate;
  logic             realign;

  // The request is honoured at its level and for one clock after it falls.
  assign gate    = oof | oof_q;
  assign realign = hit & gate;
  assign cap     = realign | (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      oof_q <= 1'b0;
      stb   <= 1'b0;
      fp    <= 1'b0;
    end else begin
      oof_q <= oof;
      stb   <= cap;
      if (cap) begin
        cnt <= '0;
        fp  <= realign;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R7: a pulse starts only if the request was high at one of the two edges before it
  assert_fp_gate_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(fp) |-> ($past(oof) || $past(oof, 2)));
  // R5: the pulse begins and ends on word strobes
  assert_fp_rise_stb_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(fp) |-> stb);
  assert_fp_fall_stb_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(fp) |-> stb);
  // R6: an accepted hit yields a strobe carrying a pulse on the next clock
  assert_realign_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (hit && gate) |=> (stb && fp));
endmodule

// File: rtl/sfa_outreg.sv
module sfa_outreg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic         los,
  input  logic [W-1:0] word_in,
  output logic [W-1:0] word_out
);
  always_ff @(posedge clk) begin
    if (rst)      word_out <= '0;
    else if (cap) word_out <= los ? '0 : word_in;
  end

  // R8: a word taken during loss of signal reads as zero
  assert_los_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (cap && los) |=> (word_out == '0));
  // R2: the word only moves on a capture
  assert_word_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(word_out));
endmodule

// File: rtl/sonet_frame_aligner.sv
module sonet_frame_aligner
  import sfa_pkg::*;
#(
  parameter int unsigned BYTE_W = SFA_BYTE_W,
  parameter int unsigned N_A1   = SFA_N_A1,
  parameter int unsigned N_A2   = SFA_N_A2,
  parameter logic [BYTE_W-1:0] A1_VAL = SFA_A1,
  parameter logic [BYTE_W-1:0] A2_VAL = SFA_A2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  input  logic              oof_req,
  input  logic              los_in,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_stb,
  output logic              frame_pulse
);
  logic [BYTE_W-1:0] last_word;
  logic              hit;
  logic              cap;

  sfa_hunt #(.W(BYTE_W), .N1(N_A1), .N2(N_A2), .A1(A1_VAL), .A2(A2_VAL)) u_hunt (
    .clk(clk), .rst(rst), .din(ser_in), .last_word(last_word), .hit(hit)
  );

  sfa_bytectl #(.W(BYTE_W)) u_ctl (
    .clk(clk), .rst(rst), .hit(hit), .oof(oof_req),
    .cap(cap), .stb(byte_stb), .fp(frame_pulse)
  );

  sfa_outreg #(.W(BYTE_W)) u_out (
    .clk(clk), .rst(rst), .cap(cap), .los(los_in),
    .word_in(last_word), .word_out(byte_out)
  );

  // R4: an accepted hit without loss of signal presents the A2 value with the pulse
  assert_a2_out_R4: assert property (@(posedge clk) disable iff (rst)
    (hit && oof_req && !los_in) |=> (byte_out == A2_VAL && frame_pulse));
endmodule

// File: tb/sonet_frame_aligner_bench.sv
`timescale 1ns/100ps
module sonet_frame_aligner_bench;
  typedef struct packed {
    logic       f;
    logic [7:0] d;
    logic [3:0] r;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst, din, oof, los;
  logic [7:0] byte_out;
  logic       byte_stb, frame_pulse;

  int   checks = 0, errors = 0;
  int   fp_count = 0, fp_len = 0;
  logic fp_prev = 1'b0;
  bit   run_mon = 0, done = 0;
  exp_t exp_q[$];
  exp_t pend_item;
  bit   pend_valid = 0;
  int   drop_cnt = 0;

  always #2.5 clk = ~clk;

  sonet_frame_aligner u_sonet_frame_aligner (
    .clk(clk), .rst(rst), .ser_in(din), .oof_req(oof), .los_in(los),
    .byte_out(byte_out), .byte_stb(byte_stb), .frame_pulse(frame_pulse)
  );

  task automatic chk(input bit ok, input int r, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", r, what, act, expv);
    end
  endtask

  // Drive one bit at the falling edge; a pending expectation is queued one bit later.
  task automatic send_bit(input logic b);
    @(negedge clk);
    if (drop_cnt > 0) begin
      drop_cnt--;
      if (drop_cnt == 0) oof = 1'b0;
    end
    din = b;
    #1;
    if (pend_valid) begin
      exp_q.push_back(pend_item);
      pend_valid = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] v, input bit ex, input bit f, input bit lv, input int r);
    for (int i = 0; i < 8; i++) begin
      send_bit(v[7-i]);
      if (i == 1) los = lv;
    end
    if (ex) begin
      pend_item  = '{f: f, d: (lv ? 8'h00 : v), r: r[3:0]};
      pend_valid = 1;
    end
  endtask

  task automatic send_zeros(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  // A1 A1 A1 A2 A2 A2; the third A2 is expected with a pulse when ex is set
  task automatic send_pattern(input bit ex, input int r);
    for (int i = 0; i < 3; i++) send_byte(8'hF6, 0, 0, 0, r);
    for (int i = 0; i < 2; i++) send_byte(8'h28, 0, 0, 0, r);
    send_byte(8'h28, ex, 1, 0, r);
  endtask

  // Monitor: pops expectations on strobes and measures frame pulses
  always @(negedge clk) begin
    if (!rst && run_mon) begin
      if (frame_pulse) fp_len++;
      else if (fp_len != 0) begin
        chk(fp_len == 8, 5, "R5 frame pulse length", fp_len, 8);
        fp_len = 0;
      end
      if (frame_pulse && !fp_prev) fp_count++;
      fp_prev = frame_pulse;
      if (byte_stb && exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        chk(byte_out == it.d, int'(it.r), "byte value", byte_out, it.d);
        chk(frame_pulse == it.f, int'(it.r), "frame pulse on strobe", frame_pulse, it.f);
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int fp_before, nstb;
    rst = 1'b1; din = 1'b0; oof = 1'b0; los = 1'b0;
    repeat (4) @(negedge clk);
    // R9: outputs idle during reset
    chk(byte_out == 8'h00, 9, "R9 reset byte_out", byte_out, 0);
    chk(byte_stb == 1'b0, 9, "R9 reset byte_stb", byte_stb, 0);
    chk(frame_pulse == 1'b0, 9, "R9 reset frame_pulse", frame_pulse, 0);
    rst = 1'b0;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      // R9: phase offset 0, first strobe after the 8th edge
      chk(byte_stb == (i == 8), 9, "R9 first strobe position", byte_stb, (i == 8));
    end
    nstb = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (byte_stb) nstb++;
    end
    // R2: one strobe per eight bit clocks
    chk(nstb == 10, 2, "R2 strobe count in 80 clocks", nstb, 10);

    run_mon = 1;
    oof = 1'b1;
    // R3 R6 R1: pattern at every offset, realigning while already locked
    for (int o = 0; o < 8; o++) begin
      send_zeros(o);
      send_pattern(1, 4);
      send_byte(8'hC1, 1, 0, 0, 1);
      send_byte(8'h5A + 8'(o), 1, 0, 0, 6);
      send_byte(8'h07, 1, 0, 0, 3);
    end
    send_zeros(24);
    chk(fp_count == 8, 6, "R6 pulses for eight realignments", fp_count, 8);

    // R8: loss of signal zeroes captured words
    send_byte(8'hA5, 1, 0, 1, 8);
    send_byte(8'h3C, 1, 0, 1, 8);
    send_byte(8'h96, 1, 0, 0, 8);
    send_zeros(16);

    // R7: request falls one clock after the last pattern bit, still accepted
    send_zeros(2);
    send_pattern(1, 7);
    drop_cnt = 1;
    send_byte(8'h44, 1, 0, 0, 7);
    send_byte(8'h55, 1, 0, 0, 7);
    send_zeros(16);
    chk(oof == 1'b0, 7, "R7 request released", oof, 0);

    // R7: request falls with the last pattern bit, rejected, boundary kept
    oof = 1'b1;
    fp_before = fp_count;
    send_zeros(3);
    drop_cnt = 48;
    send_pattern(0, 7);
    send_zeros(5);
    send_byte(8'h6B, 1, 0, 0, 7);
    send_byte(8'h19, 1, 0, 0, 7);
    send_zeros(16);
    chk(fp_count == fp_before, 7, "R7 no pulse after late release", fp_count, fp_before);

    // R7: request low, misaligned pattern ignored
    fp_before = fp_count;
    send_zeros(6);
    send_pattern(0, 7);
    send_zeros(2);
    send_byte(8'h2D, 1, 0, 0, 7);
    send_byte(8'hE3, 1, 0, 0, 2);
    send_zeros(24);
    chk(fp_count == fp_before, 7, "R7 no pulse with request low", fp_count, fp_before);
    chk(exp_q.size() == 0, 2, "R2 all expected words seen", exp_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule